// File: doc/BRIEF.md
# Binarized Neuron Accumulator

This block produces the output of one binarized neuron from a stream of beats. Each beat brings a slice of activation bits and the weight bits that belong to them. A bit value of 1 stands for +1 and 0 stands for -1, so the product of a pair is the XNOR of the two bits. Every beat reduces its slice to a signed score: each matching lane adds 1 and each differing lane subtracts 1. The scores of all beats of a neuron are summed.

When the beat flagged as last is accepted, the block adds a signed integer bias to the sum. This bias already carries the normalisation shift of the trained layer, so there is no scale multiplier and no separate offset. The block then registers one output bit, the sign of the biased sum. A single datapath serves neurons of any fan-in: the caller sets how many beats a neuron uses by placing the last flag, and sets how many lanes of the final beat are live.

Both streams use a valid/ready handshake. A beat is taken on a clock edge where `in_valid` and `in_ready` are both high. The result is offered on `out_valid` until `out_ready` takes it. While a result is waiting, `in_ready` is low, so back-pressure on the output stalls the input stream and no beat is lost. `last_lanes` and `bias` are plain control inputs. They are sampled only on the edge that accepts the last beat.

Top module: `bnn_neuron`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: In each beat a lane adds +1 to the neuron sum when its activation bit equals its weight bit, and -1 when they differ.
- R3: The scores of all accepted beats from the first beat up to and including the last-flagged beat are summed. Cycles with no accepted beat leave the sum unchanged.
- R4: On the last-flagged beat only lanes 0..n-1 count, where n = `last_lanes`. A value of 0, or of LANES or more, means all lanes count. Beats that are not last always count all lanes.
- R5: `out_bit` is 1 when the neuron sum plus the signed `bias` is greater than or equal to zero, and 0 when it is negative. A total of exactly zero gives 1.
- R6: `out_valid` rises on the clock edge after the one that accepts the last beat. It stays high, with `out_bit` stable, until a cycle with `out_ready` high.
- R7: While `out_valid` is high, `in_ready` is low. A beat offered in that time is not accepted and does not affect any result.
- R8: After each neuron the sum restarts from zero, so a neuron's result does not depend on earlier neurons.
- R9: A neuron of a single beat, flagged last on its first beat, is scored from that beat and the bias alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Beat offered |
| in_ready | output | 1 | Beat can be accepted |
| in_act | input | LANES | Activation bits, 1 = +1, 0 = -1 |
| in_wgt | input | LANES | Weight bits, 1 = +1, 0 = -1 |
| in_last | input | 1 | Beat is the final one of the neuron |
| last_lanes | input | $clog2(LANES+1) | Live lanes in the final beat (0 = all) |
| bias | input | BIAS_W | Signed folded bias, sampled with the last beat |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Result taken |
| out_bit | output | 1 | Sign of the biased sum, 1 = non-negative |

## Verification
The bench drives neurons whose biased total lands exactly on zero and on minus one. A design with a strict greater-than comparison, or with an off-by-one score, flips the output bit on these totals. It sweeps the final-beat lane count over every value. A wrong mask, or a wrong subtraction of the live-lane count, shows up as a wrong bit for one of these values. It holds `out_ready` low while the next beat is already offered. A design that accepts beats during the stall, or lets the result bit change, ends up with the wrong sum or the wrong bit. It also runs neurons back to back. A design that fails to restart the sum carries the previous neuron's total into the next result.

// File: rtl/bnn_pkg.sv
package bnn_pkg;
  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/bnn_xnor_count.sv
module bnn_xnor_count #(
  parameter int LANES = 16,
  parameter int CNT_W = $clog2(LANES + 1),
  parameter int SC_W  = CNT_W + 2
) (
  input  logic [LANES-1:0]      act,
  input  logic [LANES-1:0]      wgt,
  input  logic                  is_last,
  input  logic [CNT_W-1:0]      last_lanes,
  output logic signed [SC_W-1:0] score
);
  logic             all_lanes;
  logic [CNT_W-1:0] n_live;
  logic [LANES-1:0] keep;
  logic [CNT_W-1:0] pop;

  assign all_lanes = !is_last || (last_lanes == '0) ||
                     (int'(last_lanes) >= LANES);
  assign n_live    = all_lanes ? CNT_W'(LANES) : last_lanes;

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign keep[g] = all_lanes || (CNT_W'(g) < last_lanes);
  end

  always_comb begin
    pop = '0;
    for (int i = 0; i < LANES; i++)
      if (keep[i] && (act[i] ~^ wgt[i])) pop = pop + CNT_W'(1);
  end

  assign score = $signed({1'b0, pop, 1'b0}) - $signed({2'b00, n_live});
endmodule

// File: rtl/bnn_accum.sv
module bnn_accum #(
  parameter int LANES = 16,
  parameter int SC_W  = 7,
  parameter int ACC_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fire,
  input  logic                    last,
  input  logic signed [SC_W-1:0]  score,
  output logic signed [ACC_W-1:0] acc,
  output logic signed [ACC_W-1:0] total
);
  logic signed [ACC_W-1:0] score_ext;
  assign score_ext = ACC_W'(score);
  assign total     = acc + score_ext;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    acc <= '0;
    else if (fire) acc <= last ? '0 : total;

  // R3
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(acc));
  // R2
  score_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (int'(score) <= LANES && int'(score) >= -LANES));
endmodule

// File: rtl/bnn_sign_out.sv
module bnn_sign_out #(
  parameter int ACC_W  = 12,
  parameter int BIAS_W = 16,
  parameter int SUM_W  = 17
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fire_last,
  input  logic signed [ACC_W-1:0]  total,
  input  logic signed [BIAS_W-1:0] bias,
  input  logic                     out_ready,
  output logic                     out_valid,
  output logic                     out_bit
);
  logic signed [SUM_W-1:0] biased;
  assign biased = SUM_W'(total) + SUM_W'(bias);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else if (fire_last) begin
      out_valid <= 1'b1;
      out_bit   <= !biased[SUM_W-1];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));
  // R6
  result_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(fire_last));
endmodule

// File: rtl/bnn_neuron.sv
module bnn_neuron
  import bnn_pkg::*;
#(
  parameter int LANES     = 16,
  parameter int MAX_BEATS = 64,
  parameter int BIAS_W    = 16,
  localparam int CNT_W    = $clog2(LANES + 1),
  localparam int SC_W     = CNT_W + 2,
  localparam int ACC_W    = $clog2(LANES * MAX_BEATS + 1) + 1,
  localparam int SUM_W    = max_of(ACC_W, BIAS_W) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [LANES-1:0]         in_act,
  input  logic [LANES-1:0]         in_wgt,
  input  logic                     in_last,
  input  logic [CNT_W-1:0]         last_lanes,
  input  logic signed [BIAS_W-1:0] bias,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic                     out_bit
);
  logic                    fire, fire_last;
  logic signed [SC_W-1:0]  score;
  logic signed [ACC_W-1:0] acc, total;

  assign in_ready  = !out_valid;
  assign fire      = in_valid && in_ready;
  assign fire_last = fire && in_last;

  bnn_xnor_count #(.LANES(LANES), .CNT_W(CNT_W), .SC_W(SC_W)) u_count (
    .act(in_act), .wgt(in_wgt), .is_last(in_last),
    .last_lanes(last_lanes), .score(score));

  bnn_accum #(.LANES(LANES), .SC_W(SC_W), .ACC_W(ACC_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .fire(fire), .last(in_last),
    .score(score), .acc(acc), .total(total));

  bnn_sign_out #(.ACC_W(ACC_W), .BIAS_W(BIAS_W), .SUM_W(SUM_W)) u_sign (
    .clk(clk), .rst_n(rst_n), .fire_last(fire_last), .total(total),
    .bias(bias), .out_ready(out_ready), .out_valid(out_valid),
    .out_bit(out_bit));

  // R8
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_last |=> (acc == '0));
endmodule

// File: tb/bnn_neuron_tb.sv
module bnn_neuron_tb_top;
  localparam int LANES = 16;
  localparam int CNT_W = $clog2(LANES + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic [LANES-1:0] in_act = '0, in_wgt = '0;
  logic [CNT_W-1:0] last_lanes = '0;
  logic signed [15:0] bias = '0;
  logic in_ready, out_valid, out_bit;

  int tests = 0, fails = 0, cycles = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  bnn_neuron dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_act(in_act), .in_wgt(in_wgt), .in_last(in_last),
    .last_lanes(last_lanes), .bias(bias), .out_valid(out_valid),
    .out_ready(out_ready), .out_bit(out_bit));

  // behavioural reference
  int m_acc = 0;
  bit m_valid = 0, m_bit = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_valid = 0; m_bit = 0;
    end else begin
      bit take;
      int n, pop, sc;
      take = in_valid && !m_valid;
      if (m_valid && out_ready) m_valid = 0;
      if (take) begin
        n = LANES;
        if (in_last && last_lanes != 0 && int'(last_lanes) < LANES) n = int'(last_lanes);
        pop = 0;
        for (int i = 0; i < n; i++) if (in_act[i] == in_wgt[i]) pop++;
        sc = 2 * pop - n;
        if (in_last) begin
          m_bit = (m_acc + sc + int'(bias)) >= 0;
          m_valid = 1;
          m_acc = 0;
        end else m_acc += sc;
      end
    end
  end

  task automatic check(input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check("out_valid", out_valid, m_valid);
      check("in_ready", in_ready, !m_valid);
      if (m_valid) check("out_bit", out_bit, m_bit);
    end
  end

  task automatic beat(input logic [LANES-1:0] a, input logic [LANES-1:0] w,
                      input bit last, input int ll, input int b);
    @(negedge clk);
    in_valid = 1'b1; in_act = a; in_wgt = w; in_last = last;
    last_lanes = CNT_W'(ll); bias = 16'(b);
    while (!in_ready) @(negedge clk);
  endtask

  function automatic logic [LANES-1:0] wpat(input int mode, input logic [LANES-1:0] a);
    case (mode)
      1: return a;
      2: return ~a;
      3: return a ^ 16'h5555;
      default: return LANES'($urandom);
    endcase
  endfunction

  task automatic neuron(input int nb, input int mode, input int ll,
                        input int b, input int stall);
    logic [LANES-1:0] a;
    for (int k = 0; k < nb; k++) begin
      a = LANES'($urandom);
      if (k == nb - 1 && stall > 0) out_ready = 1'b0;
      beat(a, wpat(mode, a), k == nb - 1, ll, b);
    end
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      in_act = LANES'($urandom); in_wgt = LANES'($urandom);
      in_last = 1'b1; bias = 16'sd500;
    end
    @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("reset out_valid", out_valid, 0);
    check("reset in_ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("post-reset out_valid", out_valid, 0);

    phase = "R9"; neuron(1, 1, 0, -16, 0);       // total 0 -> 1
    phase = "R5"; neuron(1, 1, 0, -17, 0);       // total -1 -> 0
    phase = "R2"; neuron(1, 2, 0, 15, 0);        // -16+15 -> 0
    phase = "R2"; neuron(1, 2, 0, 16, 0);        // zero -> 1
    phase = "R2"; neuron(1, 3, 0, 0, 0);
    phase = "R4";
    for (int ll = 1; ll <= LANES; ll++) begin
      neuron(1, 1, ll, -ll, 0);
      neuron(1, 1, ll, -ll - 1, 0);
      neuron(3, 0, ll, 0, 0);
    end
    phase = "R3";
    neuron(4, 0, 0, 0, 0);
    neuron(64, 1, 0, -1024, 0);
    neuron(64, 2, 0, 1023, 0);
    for (int r = 0; r < 20; r++)
      neuron(1 + int'($urandom % 64), 0, int'($urandom % 17), int'($urandom % 41) - 20, 0);
    phase = "R6"; neuron(5, 0, 7, 2, 4);
    phase = "R7"; neuron(2, 1, 0, -32, 6);
    phase = "R8";
    for (int r = 0; r < 10; r++) neuron(2, r % 4, 0, int'($urandom % 9) - 4, 0);
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    fails++;
    $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule